// File: doc/BRIEF.md
# Flash Flag-Status Ready Poller

This block sits inside a serial NOR flash controller and answers one question after a program or erase has been started: has the flash finished, is it still working, or did the operation fail? On each accepted poll request it runs a short command sequence against a flash transaction engine. For each step it presents an opcode, an address byte count, a dummy cycle count and a data byte count. It then waits for the engine's response, which carries the bytes read from the flash.

A poll reads the ordinary status register first and then the flag-status register. The flash counts as ready only when both registers agree. If the flag register reports a failed program or erase, the block clears the flags and sends a write-disable before it reports the error. This cleanup is required because the write-enable latch stays set after such a failure. In wide (octal double-rate) mode the flag read is reshaped: it carries dummy cycles and fetches two bytes, and only the first byte is used. If the engine reports that it cannot perform flag reads, the result is decided by the status register alone.

Top module: `flag_poll_seq`

## Requirements
- R1: An accepted poll first issues a status read with opcode 0x05, 0 address bytes, 0 dummy cycles and 1 data byte. After that response it issues a flag read with opcode 0x70.
- R2: The flag read uses 0 address bytes, 0 dummy cycles and 1 data byte when `wide_mode` was 0 at acceptance. It uses 0 address bytes, 8 dummy cycles and 2 data bytes when `wide_mode` was 1. Only `rsp_data[7:0]` (the first byte) is decoded.
- R3: Without a flag failure, the result is ready (code 1) exactly when status bit 0 (write in progress) is 0 and flag bit 7 is 1. Otherwise the result is busy (code 0).
- R4: If flag bit 5 (erase failure) or bit 4 (program failure) is set, the block issues opcode 0x50 and then opcode 0x04. Both have 0 address bytes, 0 dummy cycles and 0 data bytes. Only after both responses does it finish, with result error (code 2).
- R5: With an error result, `err_erase` equals flag bit 5, `err_prog` equals bit 4 and `err_prot` equals bit 1. With a busy or ready result all three are 0. The result and the flags hold their values until the next done pulse.
- R6: If the flag-read response has `rsp_unsup` set, no cleanup commands are issued. The result is ready when status bit 0 was 0 and busy otherwise, and all error flags are 0.
- R7: Each accepted request produces exactly one `done` pulse, one cycle long. A `poll_req` that arrives while a poll is in progress is ignored.
- R8: While `cmd_valid` is high, the command fields stay stable until `rsp_valid` ends that command. An `rsp_valid` that arrives with no command outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_req | input | 1 | Start a poll (taken only when idle) |
| wide_mode | input | 1 | Octal double-rate framing for the flag read, sampled at acceptance |
| cmd_valid | output | 1 | A command is presented to the transaction engine |
| cmd_op | output | 8 | Command opcode |
| cmd_addr_bytes | output | CNT_W | Address byte count |
| cmd_dummy | output | DUMMY_W | Dummy cycle count |
| cmd_data_bytes | output | CNT_W | Data byte count |
| rsp_valid | input | 1 | Engine completed the current command |
| rsp_data | input | DATA_W | Returned bytes, first byte in bits 7:0 |
| rsp_unsup | input | 1 | Engine cannot perform the command (flag read) |
| done | output | 1 | One-cycle pulse at poll completion |
| result | output | 2 | 0 busy, 1 ready, 2 error |
| err_erase | output | 1 | Erase failure flag |
| err_prog | output | 1 | Program failure flag |
| err_prot | output | 1 | Protected-sector attempt flag |

## Verification
The hardest situations to reach are the cleanup path combined with wide framing and with stray or overlapping inputs. One example is a flag byte carrying a failure bit together with an unsupported response, which must not trigger cleanup. Another is a second request or a spurious response arriving mid-sequence. The bench's transaction-engine model answers with random latency and random register bytes under a fixed seed. Directed polls force each failure-bit combination, the protection bit on its own, the unsupported fallback in both status states, and stray responses and requests. The full command sequence of every poll is recorded and compared.

// File: rtl/flag_poll_pkg.sv
package flag_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SR, ST_FLAG, ST_CLR, ST_WRDIS, ST_DONE
  } st_t;

  typedef enum logic [1:0] {
    RES_BUSY  = 2'd0,
    RES_READY = 2'd1,
    RES_ERROR = 2'd2
  } res_t;

  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_RDFLAG  = 8'h70;
  localparam logic [7:0] OP_CLRFLAG = 8'h50;
  localparam logic [7:0] OP_WRDIS   = 8'h04;

  localparam int BIT_RDY   = 7;
  localparam int BIT_ERASE = 5;
  localparam int BIT_PROG  = 4;
  localparam int BIT_PROT  = 1;
  localparam int BIT_WIP   = 0;

  typedef struct packed {
    logic erase;
    logic prog;
    logic prot;
  } flags_t;

  // A program or erase failure is present in the flag byte.
  function automatic logic flag_fail(input logic [7:0] f);
    return f[BIT_ERASE] | f[BIT_PROG];
  endfunction

  // Non-error outcome: the flag byte only counts when the engine supports it.
  function automatic res_t settle(input logic sr_idle, input logic [7:0] f,
                                  input logic unsup);
    if (unsup) return sr_idle ? RES_READY : RES_BUSY;
    return (sr_idle && f[BIT_RDY]) ? RES_READY : RES_BUSY;
  endfunction

endpackage

// File: rtl/flag_poll_cmd_enc.sv
module flag_poll_cmd_enc
  import flag_poll_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int DUMMY_W    = 5,
  parameter int WIDE_DUMMY = 8
) (
  input  st_t                state,
  input  logic               wide,
  output logic               valid,
  output logic [7:0]         op,
  output logic [CNT_W-1:0]   addr_bytes,
  output logic [DUMMY_W-1:0] dummy,
  output logic [CNT_W-1:0]   data_bytes
);
  localparam logic [CNT_W-1:0]   ONE_B  = CNT_W'(1);
  localparam logic [CNT_W-1:0]   TWO_B  = CNT_W'(2);
  localparam logic [DUMMY_W-1:0] WIDE_D = DUMMY_W'(WIDE_DUMMY);

  always_comb begin
    valid      = 1'b0;
    op         = 8'h00;
    addr_bytes = '0;
    dummy      = '0;
    data_bytes = '0;
    unique case (state)
      ST_SR: begin
        valid      = 1'b1;
        op         = OP_RDSR;
        data_bytes = ONE_B;
      end
      ST_FLAG: begin
        valid      = 1'b1;
        op         = OP_RDFLAG;
        dummy      = wide ? WIDE_D : '0;
        data_bytes = wide ? TWO_B : ONE_B;
      end
      ST_CLR: begin
        valid = 1'b1;
        op    = OP_CLRFLAG;
      end
      ST_WRDIS: begin
        valid = 1'b1;
        op    = OP_WRDIS;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flag_poll_decode.sv
module flag_poll_decode
  import flag_poll_pkg::*;
(
  input  logic       sr_idle,
  input  logic [7:0] flag_byte,
  input  logic       unsup,
  output logic       cleanup,
  output res_t       res,
  output flags_t     flags
);
  always_comb begin
    cleanup     = !unsup && flag_fail(flag_byte);
    res         = settle(sr_idle, flag_byte, unsup);
    flags.erase = flag_byte[BIT_ERASE];
    flags.prog  = flag_byte[BIT_PROG];
    flags.prot  = flag_byte[BIT_PROT];
  end
endmodule

// File: rtl/flag_poll_seq.sv
module flag_poll_seq
  import flag_poll_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int DUMMY_W    = 5,
  parameter int WIDE_DUMMY = 8,
  parameter int DATA_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               poll_req,
  input  logic               wide_mode,
  output logic               cmd_valid,
  output logic [7:0]         cmd_op,
  output logic [CNT_W-1:0]   cmd_addr_bytes,
  output logic [DUMMY_W-1:0] cmd_dummy,
  output logic [CNT_W-1:0]   cmd_data_bytes,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_data,
  input  logic               rsp_unsup,
  output logic               done,
  output logic [1:0]         result,
  output logic               err_erase,
  output logic               err_prog,
  output logic               err_prot
);
  localparam int BYTE_W = 8;

  st_t    state;
  logic   wide_q;
  logic   sr_idle_q;
  res_t   res_q;
  flags_t flags_q;

  // Named events for the checker
  logic   accept_ev, sr_ev, flag_ev, clr_ev, wrdis_ev;
  logic   dec_cleanup;
  res_t   dec_res;
  flags_t dec_flags;

  // Second byte of a wide flag read is fetched but never decoded.
  logic   unused_hi;
  assign unused_hi = ^rsp_data[DATA_W-1:BYTE_W];

  assign accept_ev = (state == ST_IDLE)  && poll_req;
  assign sr_ev     = (state == ST_SR)    && rsp_valid;
  assign flag_ev   = (state == ST_FLAG)  && rsp_valid;
  assign clr_ev    = (state == ST_CLR)   && rsp_valid;
  assign wrdis_ev  = (state == ST_WRDIS) && rsp_valid;

  flag_poll_cmd_enc #(
    .CNT_W(CNT_W), .DUMMY_W(DUMMY_W), .WIDE_DUMMY(WIDE_DUMMY)
  ) u_enc (
    .state      (state),
    .wide       (wide_q),
    .valid      (cmd_valid),
    .op         (cmd_op),
    .addr_bytes (cmd_addr_bytes),
    .dummy      (cmd_dummy),
    .data_bytes (cmd_data_bytes)
  );

  flag_poll_decode u_dec (
    .sr_idle   (sr_idle_q),
    .flag_byte (rsp_data[BYTE_W-1:0]),
    .unsup     (rsp_unsup),
    .cleanup   (dec_cleanup),
    .res       (dec_res),
    .flags     (dec_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wide_q    <= 1'b0;
      sr_idle_q <= 1'b0;
      res_q     <= RES_BUSY;
      flags_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_ev) begin
          wide_q <= wide_mode;
          state  <= ST_SR;
        end
        ST_SR: if (sr_ev) begin
          sr_idle_q <= ~rsp_data[BIT_WIP];
          state     <= ST_FLAG;
        end
        ST_FLAG: if (flag_ev) begin
          if (dec_cleanup) begin
            flags_q <= dec_flags;
            state   <= ST_CLR;
          end else begin
            res_q   <= dec_res;
            flags_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_CLR: if (clr_ev) state <= ST_WRDIS;
        ST_WRDIS: if (wrdis_ev) begin
          res_q <= RES_ERROR;
          state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = (state == ST_DONE);
  assign result    = res_q;
  assign err_erase = flags_q.erase;
  assign err_prog  = flags_q.prog;
  assign err_prot  = flags_q.prot;

endmodule

// File: rtl/flag_poll_chk.sv
module flag_poll_chk
  import flag_poll_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int DUMMY_W    = 5,
  parameter int WIDE_DUMMY = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [7:0]         cmd_op,
  input logic [CNT_W-1:0]   cmd_addr_bytes,
  input logic [DUMMY_W-1:0] cmd_dummy,
  input logic [CNT_W-1:0]   cmd_data_bytes,
  input logic               rsp_valid,
  input logic               done,
  input logic [1:0]         result,
  input logic               err_erase,
  input logic               err_prog,
  input logic               err_prot
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_dummy) &&
       $stable(cmd_data_bytes) && $stable(cmd_addr_bytes)));

  assert_flag_after_sr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RDFLAG && !$past(cmd_valid && cmd_op == OP_RDFLAG))
      |-> ($past(cmd_valid) && $past(cmd_op) == OP_RDSR));

  assert_flag_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RDFLAG) |->
      (cmd_addr_bytes == '0 &&
       ((cmd_dummy == '0 && cmd_data_bytes == CNT_W'(1)) ||
        (cmd_dummy == DUMMY_W'(WIDE_DUMMY) && cmd_data_bytes == CNT_W'(2)))));

  assert_wrdis_after_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRDIS && !$past(cmd_valid && cmd_op == OP_WRDIS))
      |-> ($past(cmd_valid) && $past(cmd_op) == OP_CLRFLAG));

  assert_error_after_wrdis_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_ERROR) |-> ($past(cmd_valid) && $past(cmd_op) == OP_WRDIS));

  assert_prot_needs_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_prot |-> (err_erase || err_prog));

  assert_flags_only_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != RES_ERROR) |-> !(err_erase || err_prog || err_prot));
endmodule

bind flag_poll_seq flag_poll_chk #(
  .CNT_W(CNT_W), .DUMMY_W(DUMMY_W), .WIDE_DUMMY(WIDE_DUMMY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr_bytes(cmd_addr_bytes), .cmd_dummy(cmd_dummy),
  .cmd_data_bytes(cmd_data_bytes), .rsp_valid(rsp_valid), .done(done),
  .result(result), .err_erase(err_erase), .err_prog(err_prog),
  .err_prot(err_prot)
);

// File: tb/test_flag_poll_seq.sv
module test_flag_poll_seq;
  localparam int PERIOD = 10;
  localparam int CNT_W = 3, DUMMY_W = 5, DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, poll_req = 1'b0, wide_mode = 1'b0;
  logic cmd_valid, done, err_erase, err_prog, err_prot;
  logic [7:0] cmd_op;
  logic [CNT_W-1:0] cmd_addr_bytes, cmd_data_bytes;
  logic [DUMMY_W-1:0] cmd_dummy;
  logic rsp_valid, rsp_unsup;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0] result;

  int total = 0, bad = 0;
  bit finished = 0;

  // engine model configuration
  logic [7:0] cfg_sr, cfg_flag, cfg_flag2;
  logic cfg_unsup = 1'b0;
  bit stray_req = 0;
  int n_cmd = 0;
  logic [7:0] log_op [0:7];
  int log_addr [0:7], log_dum [0:7], log_dat [0:7];
  int n_done = 0;

  always #(PERIOD/2) clk = ~clk;

  flag_poll_seq #(.CNT_W(CNT_W), .DUMMY_W(DUMMY_W), .DATA_W(DATA_W)) i_flag_poll_seq (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .wide_mode(wide_mode),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr_bytes(cmd_addr_bytes),
    .cmd_dummy(cmd_dummy), .cmd_data_bytes(cmd_data_bytes),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_unsup(rsp_unsup),
    .done(done), .result(result), .err_erase(err_erase), .err_prog(err_prog),
    .err_prot(err_prot));

  always @(negedge clk) if (rst_n && done) n_done++;

  // transaction engine model
  initial begin
    rsp_valid = 0; rsp_data = '0; rsp_unsup = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_unsup = 0;
      if (rst_n && cmd_valid) begin
        if (n_cmd < 8) begin
          log_op[n_cmd] = cmd_op; log_addr[n_cmd] = int'(cmd_addr_bytes);
          log_dum[n_cmd] = int'(cmd_dummy); log_dat[n_cmd] = int'(cmd_data_bytes);
        end
        n_cmd++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        rsp_data = '0;
        if (cmd_op == 8'h05) rsp_data = {8'h00, cfg_sr};
        else if (cmd_op == 8'h70) begin
          rsp_data = {cfg_flag2, cfg_flag};
          rsp_unsup = cfg_unsup;
        end
        rsp_valid = 1;
      end else if (rst_n && stray_req) begin
        rsp_data = 16'hFFFF; rsp_valid = 1; stray_req = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_cleanup(input logic [7:0] f, input logic u);
    return !u && (f[5] || f[4]);
  endfunction

  function automatic int exp_result(input logic [7:0] s, input logic [7:0] f,
                                    input logic u);
    bit idle = !s[0];
    if (u) return idle ? 1 : 0;
    if (f[5] || f[4]) return 2;
    return (idle && f[7]) ? 1 : 0;
  endfunction

  task automatic poll(input logic [7:0] s, input logic [7:0] f, input logic u,
                      input logic w, input bit extra_req);
    int wait_n = 0;
    int d0;
    bit cl = exp_cleanup(f, u);
    int er = exp_result(s, f, u);
    int ef = cl ? {f[5], f[4], f[1]} : 0;
    int ncmd_exp = cl ? 4 : 2;
    cfg_sr = s; cfg_flag = f; cfg_flag2 = 8'($urandom); cfg_unsup = u;
    n_cmd = 0; d0 = n_done;
    @(negedge clk); poll_req = 1; wide_mode = w;
    @(negedge clk); poll_req = extra_req; wide_mode = ~w;
    @(negedge clk); poll_req = 0;
    while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
    check(done == 1, "R7", "done reached", done, 1);
    check(int'(result) == er, "R3", "result", result, er);
    check({err_erase, err_prog, err_prot} == 3'(ef), "R5", "flags",
          {err_erase, err_prog, err_prot}, ef);
    repeat (4) @(negedge clk);
    check(int'(result) == er && {err_erase, err_prog, err_prot} == 3'(ef),
          "R5", "held after done", {result, err_erase, err_prog, err_prot}, {er[1:0], ef[2:0]});
    check(n_done - d0 == 1, "R7", "done pulse count", n_done - d0, 1);
    check(n_cmd == ncmd_exp, cl ? "R4" : "R6", "command count", n_cmd, ncmd_exp);
    if (n_cmd >= 2) begin
      check(log_op[0] == 8'h05 && log_addr[0] == 0 && log_dum[0] == 0 && log_dat[0] == 1,
            "R1", "status read", log_op[0], 8'h05);
      check(log_op[1] == 8'h70 && log_addr[1] == 0 &&
            log_dum[1] == (w ? 8 : 0) && log_dat[1] == (w ? 2 : 1),
            "R2", "flag read shape", {log_dum[1][7:0], log_dat[1][7:0]},
            w ? 16'h0802 : 16'h0001);
    end
    if (cl && n_cmd >= 4) begin
      check(log_op[2] == 8'h50 && log_addr[2] == 0 && log_dum[2] == 0 && log_dat[2] == 0,
            "R4", "clear flags cmd", log_op[2], 8'h50);
      check(log_op[3] == 8'h04 && log_addr[3] == 0 && log_dum[3] == 0 && log_dat[3] == 0,
            "R4", "write disable cmd", log_op[3], 8'h04);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(done == 0 && cmd_valid == 0, "R7", "reset state", {done, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(done == 0 && cmd_valid == 0 && result == 2'd0, "R8", "idle after reset",
          {done, cmd_valid, result}, 0);
    // directed corners
    poll(8'h00, 8'h80, 0, 0, 0);   // ready R3
    poll(8'h01, 8'h80, 0, 0, 0);   // write in progress: busy R3
    poll(8'h00, 8'h00, 0, 1, 0);   // flag not ready, wide R2
    poll(8'h00, 8'hA0, 0, 0, 0);   // erase failure R4
    poll(8'h03, 8'h92, 0, 1, 1);   // program failure + prot, wide, extra req R7
    poll(8'h00, 8'h82, 0, 0, 0);   // prot alone, not an error R5
    poll(8'h00, 8'h30, 1, 0, 0);   // unsupported, idle: ready, no cleanup R6
    poll(8'h01, 8'h80, 1, 1, 0);   // unsupported, busy R6
    // stray response while idle must be ignored R8
    stray_req = 1;
    repeat (6) @(negedge clk);
    check(n_cmd == 0 || n_cmd == 2 || n_cmd == 4, "R8", "no command from stray", n_cmd, 0);
    check(done == 0 && cmd_valid == 0, "R8", "stray response ignored", {done, cmd_valid}, 0);
    poll(8'h00, 8'h80, 0, 0, 0);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] s = 8'($urandom) & 8'h03;
      logic [7:0] f = 8'($urandom);
      if ($urandom_range(0, 2) == 0) f[5:4] = 2'b00;
      poll(s, f, ($urandom_range(0, 5) == 0), 1'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule